// File: doc/BRIEF.md
# Dual-Channel Link Health Monitor

This block watches the private full-duplex packet link between two redundant processing channels of a safety controller. Each inbound direction delivers packets as a byte stream with a byte-valid strobe and an end-of-packet marker. Every packet ends in a 32-bit CRC. The block checks that CRC. It also counts how many packets in a row, per direction, were corrupt or never arrived inside a 1 ms transmit window. When that count exceeds the allowed limit, it requests the safe state.

Before normal operation may begin, the block takes the software version and configuration hash from the first intact packet after reset on direction 0. It compares them with the local values. It enters the run state only when both agree. The safe state is terminal until the next reset. The surrounding system drives the 1 ms tick, the local identity values and the byte streams. It uses `run_ok` to allow normal operation and `safe_req` to force the outputs off.

Top module: `link_health_mon`

## Requirements
- R1: A packet is intact when a CRC-32 over its whole length checks out. The CRC uses the reflected polynomial 0x04C11DB7 (shift constant 0xEDB88320), initial value 0xFFFFFFFF and final XOR 0xFFFFFFFF. The sender appends the complemented CRC as four bytes, least significant byte first. A packet that fails this check counts as one failure in its direction.
- R2: A tick on `tick_1ms` closes a window. If no packet ended in a direction since the previous tick (or since reset), that direction counts one failure. A packet that ends in the same cycle as the tick belongs to the window that is closing.
- R3: An intact packet clears the consecutive-failure count of its direction to zero. The count saturates and never wraps.
- R4: When a direction has 21 consecutive failures (more than FAIL_LIMIT = 20), the block moves to the safe state. Exactly 20 consecutive failures do not trip it.
- R5: Each direction is counted independently. A failure run in either direction alone is enough to trip the block.
- R6: The identity fields come from the first intact packet on direction 0 after reset. Byte 0 is the upper byte of the 16-bit version and byte 1 is its lower byte. Bytes 2..17 hold the 128-bit hash, most significant byte first. Corrupt packets are skipped for this purpose. An intact packet shorter than 22 bytes (fields plus CRC) counts as an identity mismatch.
- R7: The partner version is compatible when its upper byte (major) equals the upper byte of `local_version`; the lower byte may differ. An incompatible version leads to the safe state.
- R8: A partner hash that differs in any bit from `local_hash` leads to the safe state.
- R9: `mode` encodes 0 = startup, 1 = handshake, 2 = run, 3 = safe. The block stays in startup until the first tick. It then waits in handshake until the identity fields are known, and enters run only from handshake. `run_ok` is high exactly in run.
- R10: The safe state raises `safe_req`, drops `run_ok`, and is left only by reset, whatever packets and ticks follow.
- R11: While reset is held and just after it is released, `mode` is 0 and both `run_ok` and `safe_req` are low. Reset is asserted asynchronously and released on the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse that marks each 1 ms transmit window |
| rx_valid | input | NDIR | Byte strobe per inbound direction |
| rx_data | input | 8*NDIR | Received byte per direction, direction d in bits 8d+7..8d |
| rx_last | input | NDIR | Marks the final byte of a packet, per direction |
| local_version | input | 16 | Own software version, upper byte is the major part |
| local_hash | input | 128 | Own configuration hash |
| mode | output | 2 | Current state: 0 startup, 1 handshake, 2 run, 3 safe |
| run_ok | output | 1 | Normal operation allowed |
| safe_req | output | 1 | Safe state requested |

## Verification
The identity comparison is run through a table of first packets. The table holds an exact match, a differing minor version, differing major versions above and below the local one, one flipped hash bit and a packet too short to carry the fields. These separate the major/minor split and the full-width hash compare from the length rule. The failure counter is tried with three patterns: pure silence in one direction, corrupt packets followed by an intact one and then silence, and a mix of corrupt and missing packets in the other direction. These separate the lost-packet rule, the corrupt-packet rule, the clearing rule and the exact trip threshold of 20 against 21. Further runs check that a corrupt identity packet is skipped, that the startup and handshake states are visible in order, and that safe stays latched under later good traffic.

// File: rtl/link_mon_pkg.sv
package link_mon_pkg;

  typedef enum logic [1:0] {
    MODE_STARTUP   = 2'd0,
    MODE_HANDSHAKE = 2'd1,
    MODE_RUN       = 2'd2,
    MODE_SAFE      = 2'd3
  } lm_mode_e;

  localparam logic [31:0] CRC_SHIFT_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED       = 32'hFFFFFFFF;
  // Register value left after an intact packet including its appended CRC.
  localparam logic [31:0] CRC_GOOD_REM   = 32'hDEBB20E3;

  function automatic logic [31:0] crc_step_byte(input logic [31:0] cur, input logic [7:0] din);
    logic [31:0] acc;
    acc = cur ^ {24'd0, din};
    for (int b = 0; b < 8; b++) begin
      acc = acc[0] ? ((acc >> 1) ^ CRC_SHIFT_POLY) : (acc >> 1);
    end
    return acc;
  endfunction

endpackage

// File: rtl/lm_crc_rx.sv
module lm_crc_rx
  import link_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  input  logic       last_i,
  output logic       done_o,
  output logic       good_o
);

  logic [31:0] crc_q, crc_d, crc_upd;
  logic        done_q, done_d;
  logic        good_q, good_d;

  always_comb begin
    crc_upd = crc_step_byte(crc_q, data_i);
    crc_d   = crc_q;
    done_d  = 1'b0;
    good_d  = good_q;
    if (valid_i) begin
      crc_d = last_i ? CRC_SEED : crc_upd;
      if (last_i) begin
        done_d = 1'b1;
        good_d = (crc_upd == CRC_GOOD_REM);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q  <= CRC_SEED;
      done_q <= 1'b0;
      good_q <= 1'b0;
    end else begin
      crc_q  <= crc_d;
      done_q <= done_d;
      good_q <= good_d;
    end
  end

  assign done_o = done_q;
  assign good_o = good_q;

  // R1: a verdict appears only in the cycle after a final byte
  assert_done_after_last_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    done_q |-> $past(valid_i && last_i));

endmodule

// File: rtl/lm_fail_count.sv
module lm_fail_count #(
  parameter int LIMIT = 20
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic done_i,
  input  logic good_i,
  output logic trip_o
);

  localparam int CW = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] TOP_C = CW'(LIMIT + 1);
  localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          seen_q, seen_d;
  logic          bump, clear;

  always_comb begin
    clear  = done_i && good_i;
    bump   = (done_i && !good_i) || (tick_i && !(seen_q || done_i));
    cnt_d  = cnt_q;
    if (clear)                      cnt_d = '0;
    else if (bump && cnt_q != TOP_C) cnt_d = cnt_q + 1'b1;
    seen_d = tick_i ? 1'b0 : (seen_q || done_i);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
    end
  end

  assign trip_o = (cnt_q > LIM_C);

  // R3: an intact packet leaves the run length at zero
  assert_clear_on_good_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (done_i && good_i) |=> (cnt_q == '0));
  // R2: the run length only grows one step at a time or restarts
  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + 1'b1));
  // R3: saturation bound
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= TOP_C);

endmodule

// File: rtl/lm_ident_capture.sv
module lm_ident_capture #(
  parameter int VER_W  = 16,
  parameter int HASH_W = 128
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        data_i,
  input  logic              last_i,
  input  logic              done_i,
  input  logic              good_i,
  output logic              locked_o,
  output logic              complete_o,
  output logic [VER_W-1:0]  ver_o,
  output logic [HASH_W-1:0] hash_o
);

  localparam int FW  = VER_W + HASH_W;
  localparam int FB  = FW / 8;
  localparam int LEN = FB + 4;
  localparam int IW  = $clog2(LEN + 1);
  localparam logic [IW-1:0] FB_C  = IW'(FB);
  localparam logic [IW-1:0] LEN_C = IW'(LEN);

  logic [IW-1:0] idx_q;
  logic [FW-1:0] shift_q;
  logic          len_ok_q, locked_q, complete_q;
  logic          byte_en, lock_en;

  assign byte_en = valid_i && !locked_q;
  assign lock_en = done_i && good_i && !locked_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q      <= '0;
      shift_q    <= '0;
      len_ok_q   <= 1'b0;
      locked_q   <= 1'b0;
      complete_q <= 1'b0;
    end else begin
      if (byte_en) begin
        if (last_i) begin
          idx_q    <= '0;
          len_ok_q <= (idx_q >= LEN_C - 1'b1);
        end else if (idx_q != LEN_C) begin
          idx_q <= idx_q + 1'b1;
        end
        if (idx_q < FB_C) shift_q <= {shift_q[FW-9:0], data_i};
      end
      if (lock_en) begin
        locked_q   <= 1'b1;
        complete_q <= len_ok_q;
      end
    end
  end

  assign locked_o   = locked_q;
  assign complete_o = complete_q;
  assign ver_o      = shift_q[FW-1 -: VER_W];
  assign hash_o     = shift_q[HASH_W-1:0];

  // R6: once captured, the identity stays fixed until reset
  assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    locked_q |=> (locked_q && $stable(shift_q)));

endmodule

// File: rtl/link_health_mon.sv
module link_health_mon
  import link_mon_pkg::*;
#(
  parameter int NDIR       = 2,
  parameter int FAIL_LIMIT = 20,
  parameter int VER_W      = 16,
  parameter int MAJOR_W    = 8,
  parameter int HASH_W     = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_1ms,
  input  logic [NDIR-1:0]     rx_valid,
  input  logic [8*NDIR-1:0]   rx_data,
  input  logic [NDIR-1:0]     rx_last,
  input  logic [VER_W-1:0]    local_version,
  input  logic [HASH_W-1:0]   local_hash,
  output logic [1:0]          mode,
  output logic                run_ok,
  output logic                safe_req
);

  // reset: asynchronous assertion, clocked release
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [NDIR-1:0] pkt_done, pkt_good, dir_trip;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    lm_crc_rx u_crc (
      .clk     (clk),
      .rst_ni  (rst_sync),
      .valid_i (rx_valid[d]),
      .data_i  (rx_data[8*d +: 8]),
      .last_i  (rx_last[d]),
      .done_o  (pkt_done[d]),
      .good_o  (pkt_good[d])
    );
    lm_fail_count #(.LIMIT(FAIL_LIMIT)) u_cnt (
      .clk    (clk),
      .rst_ni (rst_sync),
      .tick_i (tick_1ms),
      .done_i (pkt_done[d]),
      .good_i (pkt_good[d]),
      .trip_o (dir_trip[d])
    );
  end

  logic              id_locked, id_complete;
  logic [VER_W-1:0]  id_ver;
  logic [HASH_W-1:0] id_hash;

  lm_ident_capture #(.VER_W(VER_W), .HASH_W(HASH_W)) u_ident (
    .clk        (clk),
    .rst_ni     (rst_sync),
    .valid_i    (rx_valid[0]),
    .data_i     (rx_data[7:0]),
    .last_i     (rx_last[0]),
    .done_i     (pkt_done[0]),
    .good_i     (pkt_good[0]),
    .locked_o   (id_locked),
    .complete_o (id_complete),
    .ver_o      (id_ver),
    .hash_o     (id_hash)
  );

  logic trip_any, ver_ok, hash_ok, ident_ok;
  assign trip_any = |dir_trip;
  assign ver_ok   = (id_ver[VER_W-1 -: MAJOR_W] == local_version[VER_W-1 -: MAJOR_W]);
  assign hash_ok  = (id_hash == local_hash);
  assign ident_ok = id_complete && ver_ok && hash_ok;

  lm_mode_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (trip_any) begin
      state_d = MODE_SAFE;
    end else begin
      unique case (state_q)
        MODE_STARTUP:   if (tick_1ms) state_d = MODE_HANDSHAKE;
        MODE_HANDSHAKE: if (id_locked) state_d = ident_ok ? MODE_RUN : MODE_SAFE;
        MODE_RUN:       state_d = MODE_RUN;
        default:        state_d = MODE_SAFE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) state_q <= MODE_STARTUP;
    else           state_q <= state_d;
  end

  assign mode     = state_q;
  assign run_ok   = (state_q == MODE_RUN);
  assign safe_req = (state_q == MODE_SAFE);

  // R10: safe is terminal
  assert_safe_hold_R10: assert property (@(posedge clk) disable iff (!rst_sync)
    (state_q == MODE_SAFE) |=> (state_q == MODE_SAFE));
  // R9: run is entered only from handshake
  assert_run_entry_R9: assert property (@(posedge clk) disable iff (!rst_sync)
    (state_q == MODE_RUN && $past(state_q) != MODE_RUN) |-> ($past(state_q) == MODE_HANDSHAKE));
  // R4: a tripped counter forces safe on the next edge
  assert_trip_safe_R4: assert property (@(posedge clk) disable iff (!rst_sync)
    trip_any |=> (state_q == MODE_SAFE));
  // R8: a known but different hash never leads to run
  assert_hash_gate_R8: assert property (@(posedge clk) disable iff (!rst_sync)
    (state_q == MODE_HANDSHAKE && id_locked && (id_hash != local_hash)) |=> (state_q == MODE_SAFE));

endmodule

// File: tb/tb_link_health_mon.sv
module tb_link_health_mon;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0]  LVER  = 16'h0305;
  localparam logic [127:0] LHASH = 128'h0123456789ABCDEF_FEDCBA9876543210;

  // identity table: {version[15:0], flip_hash, short_pkt, expected_mode[1:0]}
  localparam int NV = 6;
  localparam logic [19:0] VEC [NV] = '{
    {16'h0305, 1'b0, 1'b0, 2'd2},
    {16'h0399, 1'b0, 1'b0, 2'd2},
    {16'h0405, 1'b0, 1'b0, 2'd3},
    {16'h0205, 1'b0, 1'b0, 2'd3},
    {16'h0305, 1'b1, 1'b0, 2'd3},
    {16'h0305, 1'b0, 1'b1, 2'd3}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         tick_1ms;
  logic [1:0]   rx_valid, rx_last;
  logic [15:0]  rx_data;
  logic [1:0]   mode;
  logic         run_ok, safe_req;

  int checks = 0;
  int fails  = 0;
  logic [7:0] pb [0:31];
  int plen;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_health_mon dut (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .local_version(LVER), .local_hash(LHASH),
    .mode(mode), .run_ok(run_ok), .safe_req(safe_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic [1:0] m);
    chk(req, {29'd0, mode, run_ok}, {29'd0, m, m == 2'd2});
    chk(req, {31'd0, safe_req}, {31'd0, m == 2'd3});
  endtask

  // bit-serial reference CRC, complemented at the end; appended LSB first
  task automatic seal(input int n);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ pb[i][b];
        c  = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    c = ~c;
    for (int k = 0; k < 4; k++) pb[n+k] = c[8*k +: 8];
    plen = n + 4;
  endtask

  task automatic send(input int d);
    for (int i = 0; i < plen; i++) begin
      @(negedge clk);
      rx_valid[d] = 1'b1;
      rx_data[8*d +: 8] = pb[i];
      rx_last[d] = (i == plen - 1);
    end
    @(negedge clk);
    rx_valid[d] = 1'b0;
    rx_last[d]  = 1'b0;
    rx_data[8*d +: 8] = 8'h00;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_plain(input int d, input bit bad);
    for (int i = 0; i < 8; i++) pb[i] = 8'h10 + 8'(i);
    seal(8);
    if (bad) pb[3] = pb[3] ^ 8'h04;
    send(d);
  endtask

  task automatic send_ident(input logic [15:0] ver, input bit flip, input bit shortp, input bit bad);
    pb[0] = ver[15:8];
    pb[1] = ver[7:0];
    for (int i = 0; i < 16; i++) pb[2+i] = LHASH[127-8*i -: 8];
    if (flip) pb[9] = pb[9] ^ 8'h20;
    seal(shortp ? 10 : 18);
    if (bad) pb[0] = pb[0] ^ 8'h80;
    send(0);
  endtask

  task automatic do_tick;
    @(negedge clk); tick_1ms = 1'b1;
    @(negedge clk); tick_1ms = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // kind: 0 nothing, 1 intact, 2 corrupt
  task automatic win(input int k0, input int k1);
    if (k0 != 0) send_plain(0, k0 == 2);
    if (k1 != 0) send_plain(1, k1 == 2);
    do_tick();
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic bring_up;
    do_reset();
    send_ident(LVER, 1'b0, 1'b0, 1'b0);
    send_plain(1, 1'b0);
    do_tick();
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick_1ms = 1'b0;
    rx_valid = '0; rx_last = '0; rx_data = '0;
    repeat (3) @(negedge clk);
    chk_state("R11 in reset", 2'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_state("R11 after release", 2'd0);

    // identity table, R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      do_reset();
      send_ident(VEC[v][19:4], VEC[v][3], VEC[v][2], 1'b0);
      send_plain(1, 1'b0);
      do_tick();
      chk_state($sformatf("R7/R8/R6 identity vector %0d", v), VEC[v][1:0]);
    end

    // R9 state order
    do_reset();
    chk_state("R9 startup before tick", 2'd0);
    win(0, 1);
    chk_state("R9 handshake waits for identity", 2'd1);
    send_ident(LVER, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk_state("R9 run after identity", 2'd2);

    // R6 corrupt identity packet is skipped
    do_reset();
    send_ident(16'h0905, 1'b1, 1'b0, 1'b1);
    send_ident(LVER, 1'b0, 1'b0, 1'b0);
    send_plain(1, 1'b0);
    do_tick();
    chk_state("R6 corrupt first packet skipped", 2'd2);

    // R2 R4 silence on direction 1
    bring_up();
    for (int i = 0; i < 20; i++) win(1, 0);
    chk_state("R4 twenty misses keep run", 2'd2);
    win(1, 0);
    chk_state("R4 R2 twenty-first miss trips", 2'd3);

    // R1 R3 corrupt run, clear, silence
    bring_up();
    for (int i = 0; i < 20; i++) win(1, 2);
    chk_state("R1 twenty corrupt keep run", 2'd2);
    win(1, 1);
    for (int i = 0; i < 20; i++) win(1, 0);
    chk_state("R3 count restarted after intact", 2'd2);
    win(1, 0);
    chk_state("R3 trips after fresh run of 21", 2'd3);

    // R5 direction 0 alone, mixed corrupt and missing
    bring_up();
    for (int i = 0; i < 21; i++) win((i % 2 == 0) ? 2 : 0, 1);
    chk_state("R5 direction 0 trips alone", 2'd3);

    // R10 safe stays latched under good traffic
    for (int i = 0; i < 3; i++) win(1, 1);
    send_ident(LVER, 1'b0, 1'b0, 1'b0);
    do_tick();
    chk_state("R10 safe latched", 2'd3);
    do_reset();
    chk_state("R10 R11 reset leaves safe", 2'd0);

    finish_run();
  end

endmodule